// File: doc/BRIEF.md
# Bus Master Halt and Arbitration Controller

This block decides who drives the external pins of a 32-bit bus master. An internal cycle sequencer presents the address, function code, size, direction, data and strobe values for each bus cycle. This controller passes them to the pins while the master runs normally. When an external halt request arrives, the controller stops the master at the next bus-cycle boundary. It then floats the data lines, keeps the strobes driven at their inactive levels, and holds the address group at the values of the last completed cycle.

Arbitration keeps working while the master is halted. A bus request is granted once no operand transfer is left partly done. The grant may therefore wait across several bus cycles, and across a halt that falls in the middle of an operand. While the bus is granted away, every output group is floated. When the request is withdrawn, the grant drops one clock later, and the pins are driven again one clock after that. If the halt is still asserted at that point, the saved address values go back onto the pins. An interrupt-service inhibit is raised for as long as the master is halted.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A halt request is acted on only at a clock edge where `cyc_done` is high or `cyc_busy` is low. While a cycle is running and not completing, `irq_inhibit` stays low whatever `halt_req` does.
- R2: While halted, `data_oe` is 0.
- R3: While halted and owning the bus, `ctrl_oe` is 1 and `ctrl_out` equals the parameter `CTRL_IDLE` (default all ones).
- R4: While halted and owning the bus, `addr_oe` is 1 and `addr_out`, `fc_out`, `size_out`, `rw_out` hold the sequencer values sampled at the edge where the last bus cycle completed (`cyc_done` high while running).
- R5: While halted with no operand left partly done, a sampled `bus_req` raises `bus_grant` after that clock edge.
- R6: While `bus_grant` is 1, `addr_oe`, `ctrl_oe` and `data_oe` are all 0.
- R7: When ownership returns with halt still asserted, `addr_oe` returns to 1 and the address group again shows the values saved under R4.
- R8: `irq_inhibit` is 1 exactly while the master is halted, whether or not it owns the bus.
- R9: An operand stays open from a `cyc_done` with `opnd_end` low until a `cyc_done` with `opnd_end` high. No grant is given while an operand is open, except at the edge that closes it.
- R10: `bus_grant` falls one clock after `bus_req` is sampled low. The output enables stay 0 for that one further clock and return the clock after.
- R11: While halted and owning the bus with no bus request, a sampled low `halt_req` returns the controller to running after that edge. `irq_inhibit` then falls and the pins pass the sequencer values through.
- R12: Reset (`rst_n` low, asynchronous) gives running with the bus owned: `bus_grant` 0, `irq_inhibit` 0, `addr_oe` and `ctrl_oe` 1. While running, the address group, `ctrl_out` and `data_out` follow the sequencer inputs, and `data_oe` follows `seq_data_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | External halt request |
| bus_req | input | 1 | Request for the bus from another master |
| cyc_busy | input | 1 | A bus cycle is in progress |
| cyc_done | input | 1 | Current bus cycle completes at this edge |
| opnd_end | input | 1 | With `cyc_done`, this cycle ends the operand transfer |
| seq_addr | input | AW | Sequencer address |
| seq_fc | input | FW | Sequencer function code |
| seq_size | input | SW | Sequencer transfer size |
| seq_rw | input | 1 | Sequencer read/write |
| seq_data | input | DW | Sequencer write data |
| seq_data_oe | input | 1 | Sequencer wants the data lines driven |
| seq_ctrl | input | CW | Sequencer strobe and control levels |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | DW | Data bus value |
| addr_oe | output | 1 | Enable for address, function code, size and read/write |
| addr_out | output | AW | Address value |
| fc_out | output | FW | Function code value |
| size_out | output | SW | Size value |
| rw_out | output | 1 | Read/write value |
| ctrl_oe | output | 1 | Strobe and control group enable |
| ctrl_out | output | CW | Strobe and control levels |
| bus_grant | output | 1 | Bus granted to another master |
| irq_inhibit | output | 1 | Interrupt service held off (halted) |

## Verification
A wrong controller state shows up at the pins within one clock. A missed halt leaves `irq_inhibit` low and the strobes following the sequencer. A wrong ownership state lets an enable overlap with `bus_grant` or closes the one-clock gap after the grant drops. A stale or missed capture of the saved address group only shows while halted and owning the bus, so the bench compares the address pins on every cycle of every halt. A wrong operand-open flag shows as a grant given or withheld at the wrong `cyc_done` edge. The per-clock reference model catches each of these in the cycle it occurs.

// File: rtl/bha_pkg.sv
package bha_pkg;

  // Ownership and halt state of the master
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_GRUN  = 2'd2,
    ST_GHALT = 2'd3
  } bha_state_e;

  // Bus may be handed over: an operand closes now, or nothing is open and idle
  function automatic logic grant_window(input logic busy, input logic done,
                                        input logic last, input logic open);
    return (done && last) || (!busy && !open);
  endfunction

  // Halt may land: a cycle completes now, or no cycle is running
  function automatic logic halt_window(input logic busy, input logic done);
    return done || !busy;
  endfunction

  function automatic logic st_owns(input bha_state_e s);
    return (s == ST_RUN) || (s == ST_HALT);
  endfunction

  function automatic logic st_halted(input bha_state_e s);
    return (s == ST_HALT) || (s == ST_GHALT);
  endfunction

  function automatic logic st_granted(input bha_state_e s);
    return (s == ST_GRUN) || (s == ST_GHALT);
  endfunction

endpackage

// File: rtl/bha_opnd_track.sv
module bha_opnd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_busy,
  input  logic cyc_done,
  input  logic opnd_end,
  output logic opnd_open,
  output logic grant_ok,
  output logic halt_ok
);
  import bha_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        opnd_open <= 1'b0;
    else if (cyc_done) opnd_open <= !opnd_end;
  end

  assign grant_ok = grant_window(cyc_busy, cyc_done, opnd_end, opnd_open);
  assign halt_ok  = halt_window(cyc_busy, cyc_done);

  // R9: closing cycle clears the open operand
  a_r9_operand_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && opnd_end) |=> !opnd_open);

  // R9: a mid-operand completion leaves the operand open
  a_r9_operand_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !opnd_end) |=> opnd_open);

endmodule

// File: rtl/bha_ctrl_fsm.sv
module bha_ctrl_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                bus_req,
  input  logic                grant_ok,
  input  logic                halt_ok,
  input  logic                opnd_open,
  output bha_pkg::bha_state_e state,
  output logic                reclaim,
  output logic                bus_grant,
  output logic                halted
);
  import bha_pkg::*;

  bha_state_e nxt;
  logic       reclaim_nxt;

  // Named events for the assertions
  logic enter_halt, leave_halt, give_bus, take_back;

  always_comb begin
    nxt         = state;
    reclaim_nxt = 1'b0;
    enter_halt  = 1'b0;
    leave_halt  = 1'b0;
    give_bus    = 1'b0;
    take_back   = 1'b0;
    if (!reclaim) begin
      unique case (state)
        ST_RUN: begin
          if (bus_req && grant_ok) begin
            give_bus = 1'b1;
            nxt      = halt_req ? ST_GHALT : ST_GRUN;
          end else if (halt_req && halt_ok) begin
            enter_halt = 1'b1;
            nxt        = ST_HALT;
          end
        end
        ST_HALT: begin
          if (bus_req && !opnd_open) begin
            give_bus = 1'b1;
            nxt      = ST_GHALT;
          end else if (!halt_req) begin
            leave_halt = 1'b1;
            nxt        = ST_RUN;
          end
        end
        ST_GRUN, ST_GHALT: begin
          if (!bus_req) begin
            take_back   = 1'b1;
            reclaim_nxt = 1'b1;
            nxt         = halt_req ? ST_HALT : ST_RUN;
          end else begin
            nxt = halt_req ? ST_GHALT : ST_GRUN;
          end
        end
        default: nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      reclaim <= 1'b0;
    end else begin
      state   <= nxt;
      reclaim <= reclaim_nxt;
    end
  end

  assign bus_grant = st_granted(state);
  assign halted    = st_halted(state);

  // R1: running to halted only at a cycle boundary
  a_r1_halt_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && $past(state) == ST_RUN && !$past(reclaim)) |-> $past(halt_ok));

  // R10: grant falls one clock after the request goes low
  a_r10_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !bus_req) |=> !bus_grant);

  // R10: every grant drop is followed by a reclaim gap
  a_r10_gap_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> reclaim);

  // R11: halt release with bus owned and no request returns to running
  a_r11_leave_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !reclaim && !halt_req && !bus_req) |=> (state == ST_RUN));

  // R9: grant only rises where no operand is left open
  a_r9_grant_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(!opnd_open || grant_ok));

  // Events are mutually exclusive
  a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_halt, leave_halt, give_bus, take_back}));

endmodule

// File: rtl/bha_addr_hold.sv
module bha_addr_hold #(
  parameter int AW = 32,
  parameter int FW = 3,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [FW-1:0] in_fc,
  input  logic [SW-1:0] in_size,
  input  logic          in_rw,
  output logic [AW-1:0] sv_addr,
  output logic [FW-1:0] sv_fc,
  output logic [SW-1:0] sv_size,
  output logic          sv_rw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_addr <= '0;
      sv_fc   <= '0;
      sv_size <= '0;
      sv_rw   <= 1'b1;
    end else if (capture) begin
      sv_addr <= in_addr;
      sv_fc   <= in_fc;
      sv_size <= in_size;
      sv_rw   <= in_rw;
    end
  end

  // R4: saved values only move on a capture
  a_r4_saved_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(sv_addr) && $stable(sv_fc) && $stable(sv_size) && $stable(sv_rw)));

  // R4: a capture takes the sequencer address
  a_r4_saved_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sv_addr == $past(in_addr)));

endmodule

// File: rtl/bha_pin_drive.sv
module bha_pin_drive #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            FW        = 3,
  parameter int            SW        = 2,
  parameter int            CW        = 4,
  parameter logic [CW-1:0] CTRL_IDLE = {CW{1'b1}}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bha_pkg::bha_state_e state,
  input  logic                reclaim,
  input  logic                bus_grant,
  input  logic [AW-1:0]       seq_addr,
  input  logic [FW-1:0]       seq_fc,
  input  logic [SW-1:0]       seq_size,
  input  logic                seq_rw,
  input  logic [DW-1:0]       seq_data,
  input  logic                seq_data_oe,
  input  logic [CW-1:0]       seq_ctrl,
  input  logic [AW-1:0]       sv_addr,
  input  logic [FW-1:0]       sv_fc,
  input  logic [SW-1:0]       sv_size,
  input  logic                sv_rw,
  output logic                run_live,
  output logic                data_oe,
  output logic [DW-1:0]       data_out,
  output logic                addr_oe,
  output logic [AW-1:0]       addr_out,
  output logic [FW-1:0]       fc_out,
  output logic [SW-1:0]       size_out,
  output logic                rw_out,
  output logic                ctrl_oe,
  output logic [CW-1:0]       ctrl_out
);
  import bha_pkg::*;

  logic owning;
  logic halted_own;

  assign owning     = st_owns(state) && !reclaim;
  assign run_live   = owning && (state == ST_RUN);
  assign halted_own = owning && (state == ST_HALT);

  always_comb begin
    addr_oe  = owning;
    ctrl_oe  = owning;
    data_oe  = run_live && seq_data_oe;
    data_out = seq_data;
    if (run_live) begin
      addr_out = seq_addr;
      fc_out   = seq_fc;
      size_out = seq_size;
      rw_out   = seq_rw;
      ctrl_out = seq_ctrl;
    end else begin
      addr_out = sv_addr;
      fc_out   = sv_fc;
      size_out = sv_size;
      rw_out   = sv_rw;
      ctrl_out = CTRL_IDLE;
    end
  end

  // R6: nothing driven while another master holds the bus
  a_r6_float_granted: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (!addr_oe && !ctrl_oe && !data_oe));

  // R10: no drive during the reclaim gap
  a_r10_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim |-> (!addr_oe && !ctrl_oe && !data_oe));

  // R3: strobes idle but driven while halted on an owned bus
  a_r3_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    halted_own |-> (ctrl_oe && ctrl_out == CTRL_IDLE));

  // R2: data floated while halted
  a_r2_data_float: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !data_oe);

  // R7: address group comes back from the saved copy
  a_r7_redrive: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_oe) && state == ST_HALT) |-> (addr_out == sv_addr && fc_out == sv_fc));

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            FW        = 3,
  parameter int            SW        = 2,
  parameter int            CW        = 4,
  parameter logic [CW-1:0] CTRL_IDLE = {CW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_req,
  input  logic          bus_req,
  input  logic          cyc_busy,
  input  logic          cyc_done,
  input  logic          opnd_end,
  input  logic [AW-1:0] seq_addr,
  input  logic [FW-1:0] seq_fc,
  input  logic [SW-1:0] seq_size,
  input  logic          seq_rw,
  input  logic [DW-1:0] seq_data,
  input  logic          seq_data_oe,
  input  logic [CW-1:0] seq_ctrl,
  output logic          data_oe,
  output logic [DW-1:0] data_out,
  output logic          addr_oe,
  output logic [AW-1:0] addr_out,
  output logic [FW-1:0] fc_out,
  output logic [SW-1:0] size_out,
  output logic          rw_out,
  output logic          ctrl_oe,
  output logic [CW-1:0] ctrl_out,
  output logic          bus_grant,
  output logic          irq_inhibit
);
  import bha_pkg::*;

  logic          opnd_open, grant_ok, halt_ok;
  bha_state_e    state;
  logic          reclaim, halted, run_live, capture;
  logic [AW-1:0] sv_addr;
  logic [FW-1:0] sv_fc;
  logic [SW-1:0] sv_size;
  logic          sv_rw;

  bha_opnd_track u_opnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_busy  (cyc_busy),
    .cyc_done  (cyc_done),
    .opnd_end  (opnd_end),
    .opnd_open (opnd_open),
    .grant_ok  (grant_ok),
    .halt_ok   (halt_ok)
  );

  bha_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .bus_req   (bus_req),
    .grant_ok  (grant_ok),
    .halt_ok   (halt_ok),
    .opnd_open (opnd_open),
    .state     (state),
    .reclaim   (reclaim),
    .bus_grant (bus_grant),
    .halted    (halted)
  );

  assign capture = run_live && cyc_done;

  bha_addr_hold #(.AW(AW), .FW(FW), .SW(SW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .in_addr (seq_addr),
    .in_fc   (seq_fc),
    .in_size (seq_size),
    .in_rw   (seq_rw),
    .sv_addr (sv_addr),
    .sv_fc   (sv_fc),
    .sv_size (sv_size),
    .sv_rw   (sv_rw)
  );

  bha_pin_drive #(.AW(AW), .DW(DW), .FW(FW), .SW(SW), .CW(CW), .CTRL_IDLE(CTRL_IDLE)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .reclaim     (reclaim),
    .bus_grant   (bus_grant),
    .seq_addr    (seq_addr),
    .seq_fc      (seq_fc),
    .seq_size    (seq_size),
    .seq_rw      (seq_rw),
    .seq_data    (seq_data),
    .seq_data_oe (seq_data_oe),
    .seq_ctrl    (seq_ctrl),
    .sv_addr     (sv_addr),
    .sv_fc       (sv_fc),
    .sv_size     (sv_size),
    .sv_rw       (sv_rw),
    .run_live    (run_live),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .addr_oe     (addr_oe),
    .addr_out    (addr_out),
    .fc_out      (fc_out),
    .size_out    (size_out),
    .rw_out      (rw_out),
    .ctrl_oe     (ctrl_oe),
    .ctrl_out    (ctrl_out)
  );

  assign irq_inhibit = halted;

  // R8: inhibit never low while a halt is held with the bus granted away
  a_r8_inhibit_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && $past(bus_grant) && $past(halt_req)) |-> irq_inhibit);

  // R12: the pins follow the sequencer whenever running and owning
  a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_inhibit && addr_oe) |-> (addr_out == seq_addr && ctrl_out == seq_ctrl));

endmodule

// File: tb/sim_bus_hold_arbiter.sv
module sim_bus_hold_arbiter;
  localparam int AW = 32, DW = 32, FW = 3, SW = 2, CW = 4;
  localparam logic [CW-1:0] IDLE = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, bus_req = 0, cyc_busy = 0, cyc_done = 0, opnd_end = 0;
  logic [AW-1:0] seq_addr = '0;
  logic [FW-1:0] seq_fc = '0;
  logic [SW-1:0] seq_size = '0;
  logic seq_rw = 1'b1;
  logic [DW-1:0] seq_data = '0;
  logic seq_data_oe = 1'b0;
  logic [CW-1:0] seq_ctrl = '1;
  logic data_oe, addr_oe, rw_out, ctrl_oe, bus_grant, irq_inhibit;
  logic [DW-1:0] data_out;
  logic [AW-1:0] addr_out;
  logic [FW-1:0] fc_out;
  logic [SW-1:0] size_out;
  logic [CW-1:0] ctrl_out;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  bus_hold_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .bus_req(bus_req),
    .cyc_busy(cyc_busy), .cyc_done(cyc_done), .opnd_end(opnd_end),
    .seq_addr(seq_addr), .seq_fc(seq_fc), .seq_size(seq_size), .seq_rw(seq_rw),
    .seq_data(seq_data), .seq_data_oe(seq_data_oe), .seq_ctrl(seq_ctrl),
    .data_oe(data_oe), .data_out(data_out), .addr_oe(addr_oe), .addr_out(addr_out),
    .fc_out(fc_out), .size_out(size_out), .rw_out(rw_out), .ctrl_oe(ctrl_oe),
    .ctrl_out(ctrl_out), .bus_grant(bus_grant), .irq_inhibit(irq_inhibit)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Reference model: plain flags and counters
  bit m_halt = 0, m_granted = 0, m_open = 0;
  int m_gap = 0;
  logic [AW-1:0] m_addr = '0;
  logic [FW-1:0] m_fc = '0;
  logic [SW-1:0] m_size = '0;
  logic m_rw = 1'b1;
  bit started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_halt = 0; m_granted = 0; m_open = 0; m_gap = 0;
      m_addr = '0; m_fc = '0; m_size = '0; m_rw = 1'b1;
    end else begin
      bit was_open;
      was_open = m_open;
      if (cyc_done) m_open = !opnd_end;
      if (m_gap > 0) m_gap = m_gap - 1;
      else if (m_granted) begin
        if (!bus_req) begin m_granted = 0; m_gap = 1; end
        m_halt = halt_req;
      end else if (m_halt) begin
        if (bus_req && !was_open) m_granted = 1;
        else if (!halt_req) m_halt = 0;
      end else begin
        if (cyc_done) begin
          m_addr = seq_addr; m_fc = seq_fc; m_size = seq_size; m_rw = seq_rw;
        end
        if (bus_req && ((cyc_done && opnd_end) || (!cyc_busy && !was_open))) begin
          m_granted = 1; m_halt = halt_req;
        end else if (halt_req && (cyc_done || !cyc_busy)) m_halt = 1;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done_flag) begin
      bit own, live;
      string atag;
      own  = !m_granted && (m_gap == 0);
      live = own && !m_halt;
      atag = (own && m_halt) ? "R4" : "R12";
      chk(bus_grant == m_granted, "R5 grant", bus_grant, m_granted);
      chk(irq_inhibit == m_halt, "R8 inhibit", irq_inhibit, m_halt);
      chk(data_oe == (live && seq_data_oe), "R2 data_oe", data_oe, live && seq_data_oe);
      chk(addr_oe == own, "R6 addr_oe", addr_oe, own);
      chk(ctrl_oe == own, "R6 ctrl_oe", ctrl_oe, own);
      chk(ctrl_out == (live ? seq_ctrl : IDLE), "R3 ctrl_out", ctrl_out, live ? seq_ctrl : IDLE);
      chk(data_out == seq_data, "R12 data_out", data_out, seq_data);
      chk(addr_out == (live ? seq_addr : m_addr), atag, addr_out, live ? seq_addr : m_addr);
      chk({fc_out, size_out, rw_out} == (live ? {seq_fc, seq_size, seq_rw} : {m_fc, m_size, m_rw}),
          atag, {fc_out, size_out, rw_out}, live ? {seq_fc, seq_size, seq_rw} : {m_fc, m_size, m_rw});
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) tick();
    chk(bus_grant == 0 && irq_inhibit == 0, "R12 reset grant/inhibit", {bus_grant, irq_inhibit}, 0);
    chk(addr_oe && ctrl_oe, "R12 reset enables", {addr_oe, ctrl_oe}, 2'b11);
    rst_n = 1;
    // R12: pass-through while running
    seq_addr = 32'h1000_00A4; seq_fc = 3'd5; seq_size = 2'd2; seq_rw = 0;
    seq_data = 32'hDEAD_BEEF; seq_data_oe = 1; seq_ctrl = 4'h2; cyc_busy = 1;
    tick();
    chk(addr_out == 32'h1000_00A4 && data_oe, "R12 run pass", addr_out, 32'h1000_00A4);
    // R1: halt mid-cycle waits
    halt_req = 1;
    tick();
    chk(irq_inhibit == 0, "R1 halt mid-cycle", irq_inhibit, 0);
    cyc_done = 1; opnd_end = 1;
    tick();
    cyc_done = 0; cyc_busy = 0; opnd_end = 0;
    seq_addr = 32'h5555_0000; seq_fc = 3'd1; seq_ctrl = 4'h0;
    #1;
    chk(irq_inhibit == 1, "R8 halted", irq_inhibit, 1);
    chk(data_oe == 0, "R2 data float", data_oe, 0);
    chk(ctrl_oe && ctrl_out == IDLE, "R3 idle strobes", ctrl_out, IDLE);
    chk(addr_oe && addr_out == 32'h1000_00A4 && fc_out == 3'd5, "R4 frozen addr", addr_out, 32'h1000_00A4);
    tick(); tick();
    // R5: grant while halted
    bus_req = 1;
    tick();
    chk(bus_grant == 1, "R5 grant in halt", bus_grant, 1);
    chk(!addr_oe && !ctrl_oe && !data_oe, "R6 all float", {addr_oe, ctrl_oe, data_oe}, 0);
    chk(irq_inhibit == 1, "R8 inhibit while granted", irq_inhibit, 1);
    tick();
    // R10: release timing
    bus_req = 0;
    tick();
    chk(bus_grant == 0 && !addr_oe, "R10 grant drop gap", {bus_grant, addr_oe}, 0);
    tick();
    chk(addr_oe == 1 && addr_out == 32'h1000_00A4 && size_out == 2'd2 && rw_out == 0,
        "R7 re-drive saved", addr_out, 32'h1000_00A4);
    // R11: leave halt
    halt_req = 0;
    tick();
    chk(irq_inhibit == 0 && addr_out == 32'h5555_0000, "R11 back to run", addr_out, 32'h5555_0000);
    // R9: grant waits for operand end across two cycles
    seq_addr = 32'h2000_0000; cyc_busy = 1; bus_req = 1;
    tick();
    chk(bus_grant == 0, "R9 no grant in cycle", bus_grant, 0);
    cyc_done = 1; opnd_end = 0;
    tick();
    chk(bus_grant == 0, "R9 no grant mid-operand", bus_grant, 0);
    cyc_done = 0; seq_addr = 32'h2000_0004;
    tick();
    chk(bus_grant == 0, "R9 no grant idle-open", bus_grant, 0);
    cyc_done = 1; opnd_end = 1;
    tick();
    chk(bus_grant == 1, "R9 grant at operand end", bus_grant, 1);
    cyc_done = 0; opnd_end = 0; cyc_busy = 0; bus_req = 0;
    tick(); tick(); tick();
    // R9: halt mid-operand with request held
    cyc_busy = 1; cyc_done = 1; opnd_end = 0; halt_req = 1; bus_req = 1;
    tick();
    cyc_busy = 0; cyc_done = 0;
    tick();
    chk(bus_grant == 0 && irq_inhibit == 1, "R9 halted mid-operand no grant", bus_grant, 0);
    halt_req = 0;
    tick();
    chk(irq_inhibit == 0 && bus_grant == 0, "R11 release mid-operand", irq_inhibit, 0);
    cyc_busy = 1; cyc_done = 1; opnd_end = 1;
    tick();
    chk(bus_grant == 1, "R9 grant after finishing", bus_grant, 1);
    cyc_busy = 0; cyc_done = 0; opnd_end = 0; bus_req = 0;
    tick(); tick();
    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) halt_req = ~halt_req;
      if ($urandom_range(0, 11) == 0) bus_req = ~bus_req;
      cyc_busy    = ($urandom_range(0, 3) != 0);
      cyc_done    = cyc_busy && ($urandom_range(0, 2) == 0);
      opnd_end    = ($urandom_range(0, 1) == 1);
      seq_addr    = $urandom;
      seq_fc      = FW'($urandom);
      seq_size    = SW'($urandom);
      seq_rw      = 1'($urandom);
      seq_data    = $urandom;
      seq_data_oe = 1'($urandom);
      seq_ctrl    = CW'($urandom);
      tick();
    end
    tick();
    finish_run();
  end

endmodule